// File: doc/BRIEF.md
# Two-Frame SPI Register Host

This block is a SPI controller that turns single register requests into 17-bit serial frames for one target device. That target echoes the previous frame back on MISO. A request carries a read flag, an 8-bit address and 8-bit write data, and it is accepted with a valid/ready handshake. Only one request is in flight at any time.

A write sends one frame. A read sends a request frame, raises the select line for a programmable off time, and then sends an all-ones dummy frame. The dummy frame has two jobs: it keeps the serial clock running so the target can return its answer, and its last eight captured bits are the read result. The nine bits captured before those eight are the target's echo of the request flag and address. When that echo does not match the request, an error flag is raised next to the data.

Several timing values are inputs, and the block reads them on every cycle while it is busy. They set the serial clock half-period in system clocks, the wait from select falling to the first clock edge, the wait from the last clock edge to select rising, and the off time between the two frames of a read.

Top module: `spi_frame_host`

## Requirements
- R1: `reqReady` is high only while the block is idle. A request is taken on a cycle with `reqValid` and `reqReady` both high. `reqReady` then stays low through the cycle in which `rspDone` pulses, and returns high the cycle after.
- R2: A write keeps `ssN` low for exactly one frame of 17 `sck` rising edges. The frame shifts out, most significant bit first, a 0 flag bit, then the address bits 7..0, then the write data bits 7..0.
- R3: A read produces two frames. The first is a 1 flag bit, then the address, then eight 1 bits. The second is seventeen 1 bits. Between the two frames `ssN` is high for at least `cfgGap` system clocks, and never for less than one.
- R4: `sck` is low whenever `ssN` is high. `mosi` changes only while `sck` is low, and `miso` is captured on the rising edge of `sck`.
- R5: Inside a frame, each high phase of `sck` lasts exactly `cfgHalfDiv` system clocks, and so does each low phase between two rising edges. A value of 0 counts as 1.
- R6: `ssN` falls at least `cfgLead` system clocks before the first `sck` rising edge. The last `sck` falling edge comes at least `cfgLag` system clocks before `ssN` rises.
- R7: When a read completes, `rspData` holds the last 8 bits captured from `miso` during the dummy frame, most significant bit first.
- R8: `rspErr` is 1 with a read's `rspDone` when the first 9 bits captured in the dummy frame differ from {1, request address}. Otherwise it is 0. It is always 0 for a write.
- R9: `rspDone` is a single-cycle pulse, and `ssN` is already high when it occurs. For a write, `rspData` is 0 during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqAddr | input | 8 | Register address |
| reqWdata | input | 8 | Write data |
| cfgHalfDiv | input | 8 | System clocks per `sck` half period (0 counts as 1) |
| cfgLead | input | 8 | Minimum clocks from `ssN` falling to the first `sck` rise |
| cfgLag | input | 8 | Minimum clocks from the last `sck` fall to `ssN` rising |
| cfgGap | input | 8 | Minimum `ssN` high time between the two frames of a read |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 8 | Read result (0 for writes) |
| rspErr | output | 1 | Echo mismatch on a read |
| ssN | output | 1 | Active-low target select |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |

## Verification
The completion pulse of one transaction and the request of the next can fall in the same cycle. The bench provokes this by running a back-to-back stream: `reqValid` stays high and the next request is already on the port while the current one finishes. It judges the result in three ways. `reqReady` must be low during every `rspDone`. Each request must produce exactly its own frames, in order, on the serial lines. Each response must match its own request. A second target of the same kind is the echo path: a deliberately corrupted echo must raise `rspErr`, and the next clean read of the same address must clear it.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_LAG,
    ST_GAP,
    ST_DONE
  } hostState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadReq;    // capture request and first frame
    logic loadDummy;  // load the all-ones second frame
    logic sckRise;    // drive sck high, capture miso
    logic sckFall;    // drive sck low, advance mosi
    logic finish;     // latch result and error
  } dpCtl_t;

endpackage

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int FRAME_BITS = 17,
  parameter int DIV_W      = 8,
  parameter int DLY_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqRead,
  input  logic [DIV_W-1:0] cfgHalfDiv,
  input  logic [DLY_W-1:0] cfgLead,
  input  logic [DLY_W-1:0] cfgLag,
  input  logic [DLY_W-1:0] cfgGap,
  output logic             reqReady,
  output logic             rspDone,
  output logic             ssN,
  output dpCtl_t           ctl
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  hostState_e state, nextState;
  logic [DLY_W-1:0] dlyCnt;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfLimit;
  logic [CNT_W-1:0] bitCnt;
  logic             sckHigh;
  logic             readPend;
  logic             secondFrame;
  logic             divExp;

  assign halfLimit = (cfgHalfDiv == '0) ? DIV_W'(1) : cfgHalfDiv;
  assign divExp    = (divCnt == halfLimit - 1'b1);

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          nextState   = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (dlyCnt == cfgLead) nextState = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (divExp) begin
          if (!sckHigh) begin
            ctl.sckRise = 1'b1;
          end else begin
            ctl.sckFall = 1'b1;
            if (bitCnt == LAST_BIT) nextState = ST_LAG;
          end
        end
      end
      ST_LAG: begin
        if (dlyCnt == cfgLag) begin
          if (readPend && !secondFrame) begin
            nextState = ST_GAP;
          end else begin
            ctl.finish = 1'b1;
            nextState  = ST_DONE;
          end
        end
      end
      ST_GAP: begin
        if (dlyCnt == cfgGap) begin
          ctl.loadDummy = 1'b1;
          nextState     = ST_LEAD;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      dlyCnt      <= '0;
      divCnt      <= '0;
      bitCnt      <= '0;
      sckHigh     <= 1'b0;
      readPend    <= 1'b0;
      secondFrame <= 1'b0;
      ssN         <= 1'b1;
    end else begin
      state <= nextState;
      ssN   <= !(nextState inside {ST_LEAD, ST_SHIFT, ST_LAG});

      if (nextState != state) dlyCnt <= '0;
      else if (state inside {ST_LEAD, ST_LAG, ST_GAP}) dlyCnt <= dlyCnt + 1'b1;

      if (state == ST_SHIFT && !divExp) divCnt <= divCnt + 1'b1;
      else divCnt <= '0;

      if (ctl.sckRise) sckHigh <= 1'b1;
      else if (ctl.sckFall || state != ST_SHIFT) sckHigh <= 1'b0;

      if (ctl.loadReq || ctl.loadDummy) bitCnt <= '0;
      else if (ctl.sckFall) bitCnt <= bitCnt + 1'b1;

      if (ctl.loadReq) begin
        readPend    <= reqRead;
        secondFrame <= 1'b0;
      end else if (ctl.loadDummy) begin
        secondFrame <= 1'b1;
      end
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign rspDone  = (state == ST_DONE);

  // R1: an accepted request closes the handshake until completion
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R3: select stays released during the off time of a read
  p_gap_released_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> ssN);

endmodule

// File: rtl/spi_host_dp.sv
module spi_host_dp
  import spi_host_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              reqRead,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr
);

  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int ECHO_BITS  = 1 + ADDR_W;

  logic [FRAME_BITS-1:0] txSh;
  logic [FRAME_BITS-1:0] rxSh;
  logic [ADDR_W-1:0]     addrQ;
  logic                  rdFlag;
  logic [ECHO_BITS-1:0]  echoBits;

  assign echoBits = rxSh[FRAME_BITS-1 -: ECHO_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSh    <= '0;
      addrQ   <= '0;
      rdFlag  <= 1'b0;
      sck     <= 1'b0;
      rspData <= '0;
      rspErr  <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        txSh   <= {reqRead, reqAddr, (reqRead ? {DATA_W{1'b1}} : reqWdata)};
        rdFlag <= reqRead;
        addrQ  <= reqAddr;
      end else if (ctl.loadDummy) begin
        txSh <= '1;
      end else if (ctl.sckFall) begin
        txSh <= {txSh[FRAME_BITS-2:0], 1'b1};
      end

      if (ctl.sckRise) rxSh <= {rxSh[FRAME_BITS-2:0], miso};

      if (ctl.sckRise) sck <= 1'b1;
      else if (ctl.sckFall) sck <= 1'b0;

      if (ctl.finish) begin
        rspData <= rdFlag ? rxSh[DATA_W-1:0] : '0;
        rspErr  <= rdFlag && (echoBits != {1'b1, addrQ});
      end
    end
  end

  assign mosi = txSh[FRAME_BITS-1];

  // R5: a rise strobe only arrives while the line is low, a fall only while high
  p_rise_from_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sckRise |-> !sck);
  p_fall_from_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sckFall |-> sck);

endmodule

// File: rtl/spi_frame_host.sv
module spi_frame_host
  import spi_host_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqRead,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DIV_W-1:0]  cfgHalfDiv,
  input  logic [DLY_W-1:0]  cfgLead,
  input  logic [DLY_W-1:0]  cfgLag,
  input  logic [DLY_W-1:0]  cfgGap,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr,
  output logic              ssN,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;

  dpCtl_t ctl;

  spi_host_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .DIV_W     (DIV_W),
    .DLY_W     (DLY_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqRead   (reqRead),
    .cfgHalfDiv(cfgHalfDiv),
    .cfgLead   (cfgLead),
    .cfgLag    (cfgLag),
    .cfgGap    (cfgGap),
    .reqReady  (reqReady),
    .rspDone   (rspDone),
    .ssN       (ssN),
    .ctl       (ctl)
  );

  spi_host_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqRead (reqRead),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .rspData (rspData),
    .rspErr  (rspErr)
  );

  // R4: the clock idles low whenever the target is deselected
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> !sck);

  // R4: data out holds still through a high phase
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  // R8: a new error only shows up together with completion
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspErr) |-> rspDone);

  // R9: completion only after select is released
  p_done_deselected_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> ssN);

endmodule

// File: tb/test_spi_frame_host.sv
`timescale 1ns / 1ps
module test_spi_frame_host;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic       reqRead = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic [7:0] cfgHalfDiv = 8'd2;
  logic [7:0] cfgLead = 8'd3;
  logic [7:0] cfgLag = 8'd2;
  logic [7:0] cfgGap = 8'd4;
  logic       rspDone;
  logic [7:0] rspData;
  logic       rspErr;
  logic       ssN, sck, mosi;
  logic       miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_frame_host i_spi_frame_host (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqRead(reqRead), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgHalfDiv(cfgHalfDiv), .cfgLead(cfgLead), .cfgLag(cfgLag), .cfgGap(cfgGap),
    .rspDone(rspDone), .rspData(rspData), .rspErr(rspErr),
    .ssN(ssN), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int nChk = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard queues
  typedef struct { logic [16:0] bits; bit dummy; } frm_t;
  typedef struct { logic [7:0] data; bit err; } res_t;
  frm_t expFrm[$];
  res_t expRes[$];
  logic [7:0] modelMem [256];

  // target model: echoes the previous frame, reads return stored data
  logic [7:0]  tgtMem [256];
  logic [16:0] tgtOut = '0;
  logic [16:0] tgtIn = '0;
  logic [16:0] outSh = '0;
  int          riseCnt = 0;
  bit          inFrame = 0;
  bit          corruptReq = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      tgtMem[i]   = 8'(i * 7 + 3);
      modelMem[i] = 8'(i * 7 + 3);
    end
  end

  always @(negedge ssN) begin
    if (rstN) begin
      inFrame = 1;
      riseCnt = 0;
      outSh   = tgtOut;
      miso    = outSh[16];
    end
  end

  always @(posedge sck) begin
    if (!ssN) begin
      tgtIn = {tgtIn[15:0], mosi};
      riseCnt++;
    end
  end

  always @(negedge sck) begin
    if (!ssN) begin
      outSh = {outSh[15:0], 1'b0};
      miso  = outSh[16];
    end
  end

  always @(posedge ssN) begin
    if (inFrame && rstN) begin
      frm_t f;
      inFrame = 0;
      // R2, R3: frame length and content
      check(riseCnt == 17, "R2 rising edges per frame", riseCnt, 17);
      if (expFrm.size() == 0) begin
        check(0, "R2 unexpected frame", tgtIn, 0);
      end else begin
        f = expFrm.pop_front();
        check(tgtIn == f.bits, f.dummy ? "R3 dummy frame bits" : "R2 R3 frame bits",
              tgtIn, f.bits);
      end
      if (tgtIn[16] == 1'b0) begin
        tgtMem[tgtIn[15:8]] = tgtIn[7:0];
        tgtOut = tgtIn;
      end else begin
        tgtOut = {1'b1, tgtIn[15:8], tgtMem[tgtIn[15:8]]};
        if (corruptReq && tgtIn[15:8] != 8'hFF) begin
          tgtOut = tgtOut ^ 17'h00100;
          corruptReq = 0;
        end
      end
    end
  end

  // timing and response monitor, sampled away from the active edge
  bit   prevSs = 1, prevSck = 0, prevMosi = 0, prevDone = 0, firstRise = 0;
  int   leadCnt = 0, lowCnt = 0, highCnt = 0, ssHighCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      automatic int halfEff = (cfgHalfDiv == 0) ? 1 : int'(cfgHalfDiv);
      if (!ssN && prevSs) begin
        check(!reqReady, "R1 ready low while selected", reqReady, 0);
        if (expFrm.size() > 0 && expFrm[0].dummy) begin
          check(ssHighCnt >= int'(cfgGap) && ssHighCnt >= 1, "R3 off time between frames",
                ssHighCnt, cfgGap);
        end
        leadCnt = 1; lowCnt = 1; highCnt = 0; firstRise = 0;
      end else if (!ssN) begin
        if (sck && !prevSck) begin
          if (!firstRise) check(leadCnt >= int'(cfgLead), "R6 lead time", leadCnt, cfgLead);
          else check(lowCnt == halfEff, "R5 low phase", lowCnt, halfEff);
          firstRise = 1; highCnt = 1;
        end else if (!sck && prevSck) begin
          check(highCnt == halfEff, "R5 high phase", highCnt, halfEff);
          lowCnt = 1;
        end else if (sck) begin
          highCnt++;
          check(mosi == prevMosi, "R4 mosi stable while sck high", mosi, prevMosi);
        end else begin
          lowCnt++;
          if (!firstRise) leadCnt++;
        end
      end
      if (ssN && !prevSs) begin
        check(lowCnt >= int'(cfgLag), "R6 lag time", lowCnt, cfgLag);
        ssHighCnt = 0;
      end
      if (ssN) begin
        ssHighCnt++;
        if (sck) check(0, "R4 sck idles low", sck, 0);
      end
      if (rspDone) begin
        check(!prevDone, "R9 done is one cycle", prevDone, 0);
        check(ssN, "R9 done after release", ssN, 1);
        check(!reqReady, "R1 ready low during done", reqReady, 0);
        if (expRes.size() == 0) begin
          check(0, "R1 unexpected completion", rspData, 0);
        end else begin
          automatic res_t r = expRes.pop_front();
          check(rspData == r.data, "R7 R9 response data", rspData, r.data);
          check(rspErr == r.err, "R8 echo error flag", rspErr, r.err);
        end
      end
      prevSs = ssN; prevSck = sck; prevMosi = mosi; prevDone = rspDone;
    end
  end

  // driver: pushes expectations, then presents the request
  task automatic doReq(input bit rd, input logic [7:0] addr, input logic [7:0] wdata,
                       input bit corrupt);
    frm_t f;
    res_t r;
    if (rd) begin
      f.bits = {1'b1, addr, 8'hFF}; f.dummy = 0; expFrm.push_back(f);
      f.bits = 17'h1FFFF;           f.dummy = 1; expFrm.push_back(f);
      r.data = modelMem[addr]; r.err = corrupt;
    end else begin
      f.bits = {1'b0, addr, wdata}; f.dummy = 0; expFrm.push_back(f);
      modelMem[addr] = wdata;
      r.data = 8'h00; r.err = 0;
    end
    expRes.push_back(r);
    @(negedge clk);
    if (corrupt) corruptReq = 1;
    reqValid = 1; reqRead = rd; reqAddr = addr; reqWdata = wdata;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    reqValid = 0;
    while (expRes.size() != 0 || !reqReady) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic runTests();
    repeat (3) @(negedge clk);
    // reset state
    check(ssN == 1, "R4 reset select high", ssN, 1);
    check(sck == 0, "R4 reset sck low", sck, 0);
    check(reqReady == 1, "R1 reset ready high", reqReady, 1);
    check(rspDone == 0, "R9 reset no done", rspDone, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // config A: back-to-back stream with done and next request colliding
    doReq(0, 8'h12, 8'hA5, 0);
    doReq(1, 8'h12, 8'h00, 0);
    doReq(1, 8'h40, 8'h00, 0);
    doReq(0, 8'h80, 8'h3C, 0);
    doReq(1, 8'h80, 8'h00, 0);
    doReq(0, 8'h00, 8'hFF, 0);
    doReq(1, 8'h00, 8'h00, 0);
    waitIdle();

    // config B: zero delays, divider 0 treated as 1
    cfgHalfDiv = 8'd0; cfgLead = 8'd0; cfgLag = 8'd0; cfgGap = 8'd0;
    doReq(1, 8'h05, 8'h00, 0);
    doReq(0, 8'hFE, 8'h5A, 0);
    doReq(1, 8'hFE, 8'h00, 0);
    waitIdle();

    // R8: corrupted echo flags an error, a clean read clears it
    doReq(1, 8'h33, 8'h00, 1);
    waitIdle();
    doReq(1, 8'h33, 8'h00, 0);
    waitIdle();

    // config C: slower clock, longer lag
    cfgHalfDiv = 8'd3; cfgLead = 8'd1; cfgLag = 8'd5; cfgGap = 8'd2;
    doReq(0, 8'h7E, 8'h81, 0);
    doReq(1, 8'h7E, 8'h00, 0);
    doReq(1, 8'hFF, 8'h00, 0);
    waitIdle();
    check(expFrm.size() == 0, "R2 all frames seen", expFrm.size(), 0);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule